// File: doc/BRIEF.md
# I2C Register-Window Bridge with Localities

This block is the transaction layer behind an I2C target. The bit-level target hands it one event at a time: start-write, start-read, a written byte, a byte to read, or stop. The block reads the first written byte of a transaction as a compact register index. It translates that index into an address inside a wider back-end register space. That space is cut into equal windows, one per locality. The block then issues word or byte reads and writes on a valid/ready register port and returns read bytes to the bus.

Three registers are served inside the bridge and never reach the back end: the locality selector, the checksum-enable flag and the interrupt-capability constant. Most registers are gathered in a small buffer and written as one little-endian word when the stop arrives. The data FIFO register instead streams each byte to the back end as it arrives. The 4-byte status register can be reached at any of its byte offsets, and the bridge masks and shifts its data to match the offset.

Top module: `i2cwin_bridge`

## Requirements
- R1: After reset the bridge is idle (`evt_ready`=1, `rsp_valid`=0, `be_valid`=0), the locality is 0 and checksum enable is 0. Event codes on `evt_type` are 0 start-write, 1 start-read, 2 write byte, 3 read byte and 4 stop. Write-byte and read-byte events each produce one `rsp_valid` pulse; `rsp_nak`=1 means not acknowledged.
- R2: The first byte written after start-write is an index. The index table maps each index to a window offset: 0x00 locality select (local), 0x04 to 0x000, 0x08 interrupt enable to 0x008, 0x14 interrupt capability (local), 0x18..0x1B status to 0x018, 0x24 FIFO to 0x024, 0x30 to 0x014, 0x38 device address, 0x40 checksum enable (local), 0x48 to 0xF00 and 0x4C to 0xF04. The back-end address is that offset plus locality shifted left by `LOC_SHIFT`.
- R3: An index outside the table, and the device-address index 0x38, are NAKed.
- R4: Bytes written to a non-FIFO register are buffered, least significant byte first, with unfilled bytes zero. At stop they go out as one word write (`be_byte`=0), and only if at least one data byte came. A stop after an index alone issues nothing and keeps the index, so a later read can use it.
- R5: Each byte written to the FIFO index goes straight out as a byte write (`be_byte`=1, data in bits 7:0) before it is acknowledged. FIFO bytes are never NAKed for count, and the stop that follows issues nothing.
- R6: A fifth data byte to a non-FIFO register is NAKed and is not stored.
- R7: A status write at index 0x18+k is masked with the status write mask 0x0300C06E shifted right by 8·k. For k>0 it is a byte write to offset 0x018+k; for k=0 it is a word write.
- R8: A status read fetches the word at offset 0x018, clears bits 31:26, shifts the result right by 8·k, and returns the bytes least significant first.
- R9: A locality write takes effect only for values 0 to `LOC_COUNT`-1; other values leave the locality unchanged. A checksum-enable write keeps only bit 0. Reads of both return the stored values.
- R10: Interrupt-enable write data is ANDed with the mask 0x00000087. A read of interrupt capability returns 0x00000087 without a back-end access. A write to interrupt capability issues nothing.
- R11: The first read after an index-only write fetches one word and returns it as 4 bytes, least significant first. Further reads return 0x00.
- R12: Every read of the FIFO index makes a fresh byte read on the back end and returns bits 7:0 of the result.
- R13: A stop after any read clears the transaction. A read with no pending index, or a read after data bytes have been written, returns 0x00 with no back-end access, and the stop that follows issues nothing.
- R14: While `be_valid` is high and `be_ready` is low, the request is held stable and no bus event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Bus event present |
| evt_ready | output | 1 | Bridge can accept an event |
| evt_type | input | 3 | Event code |
| evt_data | input | 8 | Written byte for write-byte events |
| rsp_valid | output | 1 | One-cycle response for write-byte or read-byte |
| rsp_nak | output | 1 | Byte not acknowledged |
| rsp_data | output | 8 | Byte returned for a read |
| be_valid | output | 1 | Back-end request valid |
| be_ready | input | 1 | Back-end accepts the request; read data valid |
| be_write | output | 1 | 1 write, 0 read |
| be_byte | output | 1 | 1 single-byte access, 0 word access |
| be_addr | output | ADDR_W | Back-end address including locality window |
| be_wdata | output | 32 | Write data |
| be_rdata | input | 32 | Read data, sampled with be_ready |

## Verification
The bench builds the bridge with its defaults: a 16-bit back-end address, a 12-bit locality shift and five localities. With these values locality 4 is the last valid window, at 0x4000, and 5 is the first rejected value, so both edges of the locality check are driven. The 12-bit window also holds the high offsets 0xF00 and 0xF04, so the vector table checks that the locality sum does not corrupt those offsets. A back-end model that is ready only on alternate cycles keeps requests waiting, so the hold rule of R14 is checked on real traffic.

// File: rtl/i2cwin_pkg.sv
package i2cwin_pkg;

    typedef enum logic [2:0] {
        EV_START_WR = 3'd0,
        EV_START_RD = 3'd1,
        EV_WR_BYTE  = 3'd2,
        EV_RD_BYTE  = 3'd3,
        EV_STOP     = 3'd4
    } evt_e;

    typedef enum logic [3:0] {
        RK_MISS, RK_DEVADDR, RK_LOCSEL, RK_CSUM, RK_ICAP,
        RK_FIFO, RK_STS, RK_INTEN, RK_PLAIN
    } rkind_e;

    typedef enum logic [1:0] {OP_NONE, OP_SEND, OP_RECV} op_e;
    typedef enum logic [0:0] {ST_IDLE, ST_BUS} st_e;
    typedef enum logic [1:0] {PD_NONE, PD_FIFO_WR, PD_FIFO_RD, PD_FIRST_RD} pend_e;

    // compact bus indices
    localparam logic [7:0] IX_LOCSEL  = 8'h00;
    localparam logic [7:0] IX_ACCESS  = 8'h04;
    localparam logic [7:0] IX_INTEN   = 8'h08;
    localparam logic [7:0] IX_ICAP    = 8'h14;
    localparam logic [7:0] IX_STS     = 8'h18;
    localparam logic [7:0] IX_FIFO    = 8'h24;
    localparam logic [7:0] IX_IFCAP   = 8'h30;
    localparam logic [7:0] IX_DEVADDR = 8'h38;
    localparam logic [7:0] IX_CSUM    = 8'h40;
    localparam logic [7:0] IX_IDENT   = 8'h48;
    localparam logic [7:0] IX_REV     = 8'h4C;

    // offsets inside one locality window
    localparam int WIN_W = 12;
    localparam logic [WIN_W-1:0] BA_ACCESS = 12'h000;
    localparam logic [WIN_W-1:0] BA_INTEN  = 12'h008;
    localparam logic [WIN_W-1:0] BA_STS    = 12'h018;
    localparam logic [WIN_W-1:0] BA_FIFO   = 12'h024;
    localparam logic [WIN_W-1:0] BA_IFCAP  = 12'h014;
    localparam logic [WIN_W-1:0] BA_IDENT  = 12'hF00;
    localparam logic [WIN_W-1:0] BA_REV    = 12'hF04;

    localparam logic [31:0] INTEN_MASK = 32'h0000_0087;
    localparam logic [31:0] STS_WMASK  = 32'h0300_C06E;
    localparam logic [31:0] STS_RMASK  = 32'h03FF_FFFF;

endpackage

// File: rtl/i2cwin_decode.sv
module i2cwin_decode
    import i2cwin_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOC_SHIFT = 12,
    parameter int LOC_W     = 3
) (
    input  logic [7:0]        idx,
    input  logic [LOC_W-1:0]  loc,
    output rkind_e            kind,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ofs
);

    logic [WIN_W-1:0] base;

    always_comb begin
        kind = RK_MISS;
        base = '0;
        ofs  = '0;
        case (idx)
            IX_LOCSEL:  kind = RK_LOCSEL;
            IX_CSUM:    kind = RK_CSUM;
            IX_ICAP:    kind = RK_ICAP;
            IX_DEVADDR: kind = RK_DEVADDR;
            IX_ACCESS:  begin kind = RK_PLAIN; base = BA_ACCESS; end
            IX_INTEN:   begin kind = RK_INTEN; base = BA_INTEN;  end
            IX_FIFO:    begin kind = RK_FIFO;  base = BA_FIFO;   end
            IX_IFCAP:   begin kind = RK_PLAIN; base = BA_IFCAP;  end
            IX_IDENT:   begin kind = RK_PLAIN; base = BA_IDENT;  end
            IX_REV:     begin kind = RK_PLAIN; base = BA_REV;    end
            IX_STS, IX_STS + 8'd1, IX_STS + 8'd2, IX_STS + 8'd3: begin
                kind = RK_STS;
                base = BA_STS;
                ofs  = 2'(idx - IX_STS);
            end
            default: kind = RK_MISS;
        endcase
        addr = ADDR_W'(base) + (ADDR_W'(loc) << LOC_SHIFT);
    end

endmodule

// File: rtl/i2cwin_shape.sv
module i2cwin_shape
    import i2cwin_pkg::*;
(
    input  rkind_e      kind,
    input  logic [1:0]  ofs,
    input  logic [31:0] wword,
    input  logic [31:0] rword,
    output logic [31:0] wout,
    output logic [31:0] rout,
    output logic        wbyte
);

    logic [4:0] sh;
    assign sh = {ofs, 3'b000};

    always_comb begin
        wout  = wword;
        rout  = rword;
        wbyte = 1'b0;
        case (kind)
            RK_INTEN: wout = wword & INTEN_MASK;
            RK_STS: begin
                wout  = wword & (STS_WMASK >> sh);
                wbyte = (ofs != 2'd0);
                rout  = (rword & STS_RMASK) >> sh;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2cwin_bridge.sv
module i2cwin_bridge
    import i2cwin_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOC_SHIFT = 12,
    parameter int LOC_COUNT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [2:0]        evt_type,
    input  logic [7:0]        evt_data,
    output logic              rsp_valid,
    output logic              rsp_nak,
    output logic [7:0]        rsp_data,
    output logic              be_valid,
    input  logic              be_ready,
    output logic              be_write,
    output logic              be_byte,
    output logic [ADDR_W-1:0] be_addr,
    output logic [31:0]       be_wdata,
    input  logic [31:0]       be_rdata
);

    localparam int LOC_W   = (LOC_COUNT > 1) ? $clog2(LOC_COUNT) : 1;
    localparam int BUF_MAX = 5;   // index plus four data bytes

    typedef struct packed {
        st_e               st;
        pend_e             pend;
        op_e               op;
        logic [2:0]        cnt;
        rkind_e            kind;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        ofs;
        logic [31:0]       dbuf;
        logic [LOC_W-1:0]  loc;
        logic              csum;
        logic              be_wr;
        logic              be_byte;
        logic [ADDR_W-1:0] be_addr;
        logic [31:0]       be_wdata;
        logic              rsp_v;
        logic              rsp_nak;
        logic [7:0]        rsp_d;
    } bstate_t;

    bstate_t s_q, s_d;

    rkind_e            dec_kind;
    logic [ADDR_W-1:0] dec_addr;
    logic [1:0]        dec_ofs;
    logic [31:0]       sh_wout, sh_rout;
    logic              sh_wbyte;

    i2cwin_decode #(
        .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .LOC_W(LOC_W)
    ) u_dec (
        .idx(evt_data), .loc(s_q.loc),
        .kind(dec_kind), .addr(dec_addr), .ofs(dec_ofs)
    );

    i2cwin_shape u_shape (
        .kind(s_q.kind), .ofs(s_q.ofs),
        .wword(s_q.dbuf), .rword(be_rdata),
        .wout(sh_wout), .rout(sh_rout), .wbyte(sh_wbyte)
    );

    function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] k);
        return w[{k, 3'b000} +: 8];
    endfunction

    function automatic bstate_t clear_txn(input bstate_t s);
        bstate_t r;
        r      = s;
        r.op   = OP_NONE;
        r.cnt  = '0;
        r.kind = RK_MISS;
        r.addr = '0;
        r.ofs  = '0;
        r.dbuf = '0;
        return r;
    endfunction

    function automatic bstate_t issue(input bstate_t s, input logic wr, input logic by,
                                      input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                                      input pend_e p);
        bstate_t r;
        r          = s;
        r.st       = ST_BUS;
        r.be_wr    = wr;
        r.be_byte  = by;
        r.be_addr  = a;
        r.be_wdata = wd;
        r.pend     = p;
        return r;
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.rsp_v   = 1'b0;
        s_d.rsp_nak = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (evt_valid) begin
                    case (evt_type)
                        EV_START_WR: s_d = clear_txn(s_d);
                        EV_START_RD: ;
                        EV_WR_BYTE: begin
                            s_d.rsp_v = 1'b1;
                            if (s_q.cnt == 3'd0) begin
                                if (dec_kind == RK_MISS || dec_kind == RK_DEVADDR) begin
                                    s_d.rsp_nak = 1'b1;
                                end else begin
                                    s_d.kind = dec_kind;
                                    s_d.addr = dec_addr;
                                    s_d.ofs  = dec_ofs;
                                    s_d.cnt  = 3'd1;
                                    s_d.op   = OP_SEND;
                                end
                            end else if (s_q.kind == RK_FIFO) begin
                                s_d.op    = OP_SEND;
                                s_d.rsp_v = 1'b0;
                                s_d = issue(s_d, 1'b1, 1'b1, s_q.addr, {24'd0, evt_data}, PD_FIFO_WR);
                            end else if (s_q.cnt < 3'(BUF_MAX)) begin
                                s_d.dbuf[{2'(s_q.cnt - 3'd1), 3'b000} +: 8] = evt_data;
                                s_d.cnt = s_q.cnt + 3'd1;
                                s_d.op  = OP_SEND;
                            end else begin
                                s_d.rsp_nak = 1'b1;
                            end
                        end
                        EV_RD_BYTE: begin
                            s_d.rsp_v = 1'b1;
                            s_d.rsp_d = 8'h00;
                            if (s_q.op == OP_RECV) begin
                                if (s_q.kind == RK_FIFO) begin
                                    s_d.rsp_v = 1'b0;
                                    s_d = issue(s_d, 1'b0, 1'b1, s_q.addr, '0, PD_FIFO_RD);
                                end else if (s_q.cnt >= 3'd2 && s_q.cnt < 3'(BUF_MAX)) begin
                                    s_d.rsp_d = byte_of(s_q.dbuf, 2'(s_q.cnt - 3'd1));
                                    s_d.cnt   = s_q.cnt + 3'd1;
                                end
                            end else if (s_q.op == OP_SEND && s_q.cnt == 3'd1) begin
                                s_d.op = OP_RECV;
                                case (s_q.kind)
                                    RK_LOCSEL: s_d.dbuf = 32'(s_q.loc);
                                    RK_CSUM:   s_d.dbuf = {31'd0, s_q.csum};
                                    RK_ICAP:   s_d.dbuf = INTEN_MASK;
                                    default:   ;
                                endcase
                                if (s_q.kind == RK_FIFO) begin
                                    s_d.rsp_v = 1'b0;
                                    s_d = issue(s_d, 1'b0, 1'b1, s_q.addr, '0, PD_FIFO_RD);
                                end else if (s_q.kind == RK_LOCSEL || s_q.kind == RK_CSUM ||
                                             s_q.kind == RK_ICAP) begin
                                    s_d.rsp_d = s_d.dbuf[7:0];
                                    s_d.cnt   = 3'd2;
                                end else begin
                                    s_d.rsp_v = 1'b0;
                                    s_d = issue(s_d, 1'b0, 1'b0, s_q.addr, '0, PD_FIRST_RD);
                                end
                            end else begin
                                s_d.op = OP_RECV;
                            end
                        end
                        EV_STOP: begin
                            if (s_q.op == OP_SEND && s_q.cnt > 3'd1) begin
                                case (s_q.kind)
                                    RK_LOCSEL: begin
                                        if (s_q.dbuf[7:0] < 8'(LOC_COUNT))
                                            s_d.loc = LOC_W'(s_q.dbuf[7:0]);
                                    end
                                    RK_CSUM: s_d.csum = s_q.dbuf[0];
                                    RK_PLAIN, RK_INTEN, RK_STS:
                                        s_d = issue(s_d, 1'b1, sh_wbyte,
                                                    s_q.addr + ADDR_W'(s_q.ofs), sh_wout, PD_NONE);
                                    default: ;
                                endcase
                                s_d = clear_txn(s_d);
                            end else if (s_q.op != OP_SEND) begin
                                s_d = clear_txn(s_d);
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_BUS: begin
                if (be_ready) begin
                    s_d.st   = ST_IDLE;
                    s_d.pend = PD_NONE;
                    case (s_q.pend)
                        PD_FIFO_WR: s_d.rsp_v = 1'b1;
                        PD_FIFO_RD: begin
                            s_d.rsp_v = 1'b1;
                            s_d.rsp_d = be_rdata[7:0];
                        end
                        PD_FIRST_RD: begin
                            s_d.rsp_v = 1'b1;
                            s_d.dbuf  = sh_rout;
                            s_d.rsp_d = sh_rout[7:0];
                            s_d.cnt   = 3'd2;
                        end
                        default: ;
                    endcase
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt_ready = (s_q.st == ST_IDLE);
    assign rsp_valid = s_q.rsp_v;
    assign rsp_nak   = s_q.rsp_nak;
    assign rsp_data  = s_q.rsp_d;
    assign be_valid  = (s_q.st == ST_BUS);
    assign be_write  = s_q.be_wr;
    assign be_byte   = s_q.be_byte;
    assign be_addr   = s_q.be_addr;
    assign be_wdata  = s_q.be_wdata;

endmodule

// File: rtl/i2cwin_checker.sv
module i2cwin_checker
    import i2cwin_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOC_SHIFT = 12,
    parameter int LOC_COUNT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_ready,
    input logic              rsp_valid,
    input logic              be_valid,
    input logic              be_ready,
    input logic              be_write,
    input logic              be_byte,
    input logic [ADDR_W-1:0] be_addr,
    input logic [31:0]       be_wdata
);

    logic [LOC_SHIFT-1:0] win_ofs;
    assign win_ofs = be_addr[LOC_SHIFT-1:0];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && !be_ready |=> be_valid && $stable(be_addr) && $stable(be_wdata)
                                   && $stable(be_write) && $stable(be_byte)); // R14

    AST_NO_EVT_WHILE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> !evt_ready); // R14

    AST_RSP_NOT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !be_valid); // R14

    AST_LOC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (32'(be_addr[ADDR_W-1:LOC_SHIFT]) < LOC_COUNT)); // R2

    AST_BYTE_WR_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && be_write && be_byte |->
            (win_ofs == LOC_SHIFT'(BA_FIFO) || win_ofs == LOC_SHIFT'(BA_STS + 12'd1) ||
             win_ofs == LOC_SHIFT'(BA_STS + 12'd2) || win_ofs == LOC_SHIFT'(BA_STS + 12'd3))); // R7

    AST_INTEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && be_write && win_ofs == LOC_SHIFT'(BA_INTEN) |->
            ((be_wdata & ~INTEN_MASK) == 32'd0)); // R10

    AST_STS_WORD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && be_write && !be_byte && win_ofs == LOC_SHIFT'(BA_STS) |->
            ((be_wdata & ~STS_WMASK) == 32'd0)); // R7

endmodule

bind i2cwin_bridge i2cwin_checker #(
    .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .LOC_COUNT(LOC_COUNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_ready(evt_ready), .rsp_valid(rsp_valid),
    .be_valid(be_valid), .be_ready(be_ready), .be_write(be_write),
    .be_byte(be_byte), .be_addr(be_addr), .be_wdata(be_wdata)
);

// File: tb/sim_i2cwin_bridge.sv
module sim_i2cwin_bridge;
    import i2cwin_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [2:0]  evt_type = 3'd0;
    logic [7:0]  evt_data = 8'd0;
    logic        rsp_valid, rsp_nak;
    logic [7:0]  rsp_data;
    logic        be_valid, be_ready, be_write, be_byte;
    logic [15:0] be_addr;
    logic [31:0] be_wdata, be_rdata;

    i2cwin_bridge u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_type(evt_type), .evt_data(evt_data), .rsp_valid(rsp_valid),
        .rsp_nak(rsp_nak), .rsp_data(rsp_data), .be_valid(be_valid),
        .be_ready(be_ready), .be_write(be_write), .be_byte(be_byte),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata)
    );

    // back-end model
    function automatic logic [31:0] bmod(input logic [15:0] a);
        return {a[7:0] ^ 8'hC3, 8'h96, a[15:8], a[7:0]};
    endfunction
    assign be_rdata = bmod(be_addr);

    logic tgl;
    always @(posedge clk) tgl <= !rst_n ? 1'b0 : ~tgl;
    assign be_ready = be_valid & tgl;

    int          wcnt = 0, rcnt = 0;
    logic [15:0] l_addr = '0;
    logic [31:0] l_wdata = '0;
    logic        l_byte = 1'b0;
    always @(posedge clk) begin
        if (be_valid && be_ready) begin
            l_addr <= be_addr;
            l_byte <= be_byte;
            if (be_write) begin
                wcnt    <= wcnt + 1;
                l_wdata <= be_wdata;
            end else begin
                rcnt <= rcnt + 1;
            end
        end
    end

    int nchk = 0, nerr = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put_evt(input logic [2:0] t, input logic [7:0] d);
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        evt_type  = t;
        evt_data  = d;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic get_rsp(output logic nak, output logic [7:0] d);
        int n = 0;
        while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
        if (rsp_valid) begin nak = rsp_nak; d = rsp_data; end
        else begin nak = 1'bx; d = 8'hxx; end
    endtask

    task automatic wr(input logic [7:0] d, input logic exp_nak, input string req);
        logic nk; logic [7:0] x;
        put_evt(EV_WR_BYTE, d);
        get_rsp(nk, x);
        chk(req, {31'd0, nk}, {31'd0, exp_nak});
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        logic nk; logic [7:0] x;
        put_evt(EV_RD_BYTE, 8'd0);
        get_rsp(nk, x);
        chk(req, {24'd0, x}, {24'd0, exp});
    endtask

    task automatic ctl(input logic [2:0] t);
        put_evt(t, 8'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_read(input logic [7:0] idx, input string req);
        ctl(EV_START_WR); wr(idx, 1'b0, req); ctl(EV_STOP); ctl(EV_START_RD);
    endtask

    task automatic wr_reg1(input logic [7:0] idx, input logic [7:0] d, input string req);
        ctl(EV_START_WR); wr(idx, 1'b0, req); wr(d, 1'b0, req); ctl(EV_STOP);
    endtask

    // idx, nbytes, data, expected addr, expected data, expected byte flag
    localparam int NV = 9;
    localparam logic [91:0] VECS [NV] = '{
        {8'h04, 3'd1, 32'h0000_00A5, 16'h0000, 32'h0000_00A5, 1'b0},
        {8'h08, 3'd4, 32'hFFFF_FFFF, 16'h0008, 32'h0000_0087, 1'b0},
        {8'h18, 3'd4, 32'hFFFF_FFFF, 16'h0018, 32'h0300_C06E, 1'b0},
        {8'h18, 3'd2, 32'h0000_FFFF, 16'h0018, 32'h0000_C06E, 1'b0},
        {8'h19, 3'd1, 32'h0000_00FF, 16'h0019, 32'h0000_00C0, 1'b1},
        {8'h1B, 3'd1, 32'h0000_00FF, 16'h001B, 32'h0000_0003, 1'b1},
        {8'h4C, 3'd4, 32'h1234_5678, 16'h0F04, 32'h1234_5678, 1'b0},
        {8'h48, 3'd2, 32'h0000_BEEF, 16'h0F00, 32'h0000_BEEF, 1'b0},
        {8'h30, 3'd3, 32'h00AB_CDEF, 16'h0014, 32'h00AB_CDEF, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R14 watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 evt_ready", {31'd0, evt_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 be_valid", {31'd0, be_valid}, 32'd0);
        sel_read(8'h00, "R1"); rd(8'h00, "R1 locality after reset"); ctl(EV_STOP);
        sel_read(8'h40, "R1"); rd(8'h00, "R1 csum after reset"); ctl(EV_STOP);

        // vector walk: buffered writes committed at stop
        for (int i = 0; i < NV; i++) begin
            logic [91:0] v;
            v  = VECS[i];
            w0 = wcnt;
            ctl(EV_START_WR);
            wr(v[91:84], 1'b0, "R2 index ack");
            for (int b = 0; b < int'(v[83:81]); b++) begin
                wr(v[49 + 8*b +: 8], 1'b0, "R4 data ack");
                chk("R4 no write before stop", wcnt, w0);
            end
            ctl(EV_STOP);
            chk("R4 one write at stop", wcnt, w0 + 1);
            chk("R7 addr", {16'd0, l_addr}, {16'd0, v[48:33]});
            chk("R7 data", l_wdata, v[32:1]);
            chk("R7 byte flag", {31'd0, l_byte}, {31'd0, v[0]});
        end

        // index-only stop then read word
        w0 = wcnt; r0 = rcnt;
        sel_read(8'h4C, "R4");
        chk("R4 index-only stop issues nothing", wcnt, w0);
        rd(8'h04, "R11 byte0"); rd(8'h0F, "R11 byte1");
        rd(8'h96, "R11 byte2"); rd(8'hC7, "R11 byte3");
        rd(8'h00, "R11 past cache");
        chk("R11 single fetch", rcnt, r0 + 1);
        chk("R11 fetch addr", {16'd0, l_addr}, 32'h0F04);
        ctl(EV_STOP);
        r0 = rcnt;
        ctl(EV_START_RD);
        rd(8'h00, "R13 read after clear");
        chk("R13 no access", rcnt, r0);
        ctl(EV_STOP);

        // status read at offset 2
        sel_read(8'h1A, "R8");
        rd(8'h96, "R8 byte0"); rd(8'h03, "R8 byte1"); rd(8'h00, "R8 byte2");
        chk("R8 addr base", {16'd0, l_addr}, 32'h0018);
        ctl(EV_STOP);

        // interrupt capability
        r0 = rcnt; w0 = wcnt;
        sel_read(8'h14, "R10");
        rd(8'h87, "R10 icap0"); rd(8'h00, "R10 icap1");
        rd(8'h00, "R10 icap2"); rd(8'h00, "R10 icap3");
        chk("R10 icap local", rcnt, r0);
        ctl(EV_STOP);
        wr_reg1(8'h14, 8'hFF, "R10 icap write");
        chk("R10 icap write no effect", wcnt, w0);

        // FIFO writes
        w0 = wcnt;
        ctl(EV_START_WR); wr(8'h24, 1'b0, "R5");
        wr(8'h11, 1'b0, "R5 fifo byte");
        chk("R5 immediate", wcnt, w0 + 1);
        chk("R5 addr", {16'd0, l_addr}, 32'h0024);
        chk("R5 data", l_wdata, 32'h11);
        chk("R5 byte", {31'd0, l_byte}, 32'd1);
        for (int b = 0; b < 5; b++) wr(8'h22 + 8'(b), 1'b0, "R5 no overflow nak");
        chk("R5 count", wcnt, w0 + 6);
        ctl(EV_STOP);
        chk("R5 stop issues nothing", wcnt, w0 + 6);

        // FIFO reads
        r0 = rcnt;
        sel_read(8'h24, "R12");
        rd(8'h24, "R12 first"); rd(8'h24, "R12 second");
        chk("R12 fresh fetch each", rcnt, r0 + 2);
        chk("R12 byte access", {31'd0, l_byte}, 32'd1);
        ctl(EV_STOP);

        // overflow
        w0 = wcnt;
        ctl(EV_START_WR); wr(8'h04, 1'b0, "R6");
        wr(8'h11, 1'b0, "R6"); wr(8'h22, 1'b0, "R6");
        wr(8'h33, 1'b0, "R6"); wr(8'h44, 1'b0, "R6");
        wr(8'h55, 1'b1, "R6 fifth byte nak");
        ctl(EV_STOP);
        chk("R6 write kept", l_wdata, 32'h4433_2211);
        chk("R6 one write", wcnt, w0 + 1);

        // NAK cases
        w0 = wcnt;
        ctl(EV_START_WR);
        wr(8'h7F, 1'b1, "R3 unknown index");
        wr(8'h38, 1'b1, "R3 device address");
        ctl(EV_STOP);
        chk("R3 nothing issued", wcnt, w0);

        // localities
        wr_reg1(8'h00, 8'h03, "R9");
        wr_reg1(8'h04, 8'h5A, "R2");
        chk("R2 locality 3 addr", {16'd0, l_addr}, 32'h3000);
        wr_reg1(8'h00, 8'h07, "R9");
        sel_read(8'h00, "R9"); rd(8'h03, "R9 invalid ignored"); ctl(EV_STOP);
        wr_reg1(8'h00, 8'h04, "R9");
        wr_reg1(8'h08, 8'hFF, "R2");
        chk("R2 locality 4 addr", {16'd0, l_addr}, 32'h4008);
        chk("R10 masked in window 4", l_wdata, 32'h87);
        wr_reg1(8'h00, 8'h05, "R9");
        sel_read(8'h00, "R9"); rd(8'h04, "R9 five rejected"); ctl(EV_STOP);
        wr_reg1(8'h40, 8'hFF, "R9");
        sel_read(8'h40, "R9"); rd(8'h01, "R9 csum bit0"); ctl(EV_STOP);

        // read after data bytes
        w0 = wcnt; r0 = rcnt;
        ctl(EV_START_WR); wr(8'h04, 1'b0, "R13"); wr(8'h01, 1'b0, "R13");
        ctl(EV_START_RD);
        rd(8'h00, "R13 read after data");
        chk("R13 no read access", rcnt, r0);
        ctl(EV_STOP);
        chk("R13 stop after read no write", wcnt, w0);

        // reset restores locality and checksum
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sel_read(8'h00, "R1"); rd(8'h00, "R1 locality reset"); ctl(EV_STOP);
        sel_read(8'h40, "R1"); rd(8'h00, "R1 csum reset"); ctl(EV_STOP);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule